// File: doc/BRIEF.md
# Two-Write Three-Read Register File

This block is a register file that accepts two independent writes and serves three independent reads on every clock edge. It is made only of simple memories that each have one write port and one read port. Each write port has its own bank. The bank is copied once per read port, so every read port has a private copy of both banks.

A one-bit owner table, built from flip-flops, records for each address which write port stored the newest value. A read port samples its owner bit together with both bank copies, then a 2-to-1 mux returns the newest value. The owner table is the only state that is reset. The storage arrays are left as they are, so an address holds no defined value until something writes it.

Top module: `regfile_2w3r`

## Requirements
- R1: A write on port 0 (`wen0` high) stores `wdata0` at `waddr0`. A read of that address issued at any later edge returns it, provided no newer write to that address has occurred.
- R2: A write on port 1 (`wen1` high) stores `wdata1` at `waddr1`, with the same visibility as R1.
- R3: Writes on both ports in the same cycle to different addresses both take effect.
- R4: When both ports write the same address in the same cycle, the port 1 data is kept and the port 0 data is discarded.
- R5: The three read ports take independent addresses and are all served in every cycle, while both write ports are active.
- R6: Reads are synchronous. Read port k samples address slice k of `raddr` (bits k*5+4 down to k*5) at a rising edge and drives the data on slice k of `rdata` (bits k*32+31 down to k*32) until the next edge.
- R7: A read of an address that is written at the same edge returns the value held before that write. No bypass is applied.
- R8: Reset (`rst_n` low) points every address at port 0's bank without erasing either bank. An address last written by port 1 before reset therefore reads its last port 0 value afterwards.
- R9: A port 0 write to an address last written by port 1 makes later reads return the port 0 data.
- R10: A port with its write enable low changes nothing, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the owner table |
| wen0 | input | 1 | Write enable, port 0 |
| waddr0 | input | 5 | Write address, port 0 |
| wdata0 | input | 32 | Write data, port 0 |
| wen1 | input | 1 | Write enable, port 1 (wins on same-address collision) |
| waddr1 | input | 5 | Write address, port 1 |
| wdata1 | input | 32 | Write data, port 1 |
| raddr | input | 15 | Three packed 5-bit read addresses, port k at bits k*5+4 down to k*5 |
| rdata | output | 96 | Three packed 32-bit read results, port k at bits k*32+31 down to k*32 |

## Verification
A wrong owner bit makes a read return the stale bank, while the bank data itself is correct. Such an error shows at the ports only when the address is next read after the two banks have diverged, one cycle after that read is issued. The bench therefore drives collisions, alternating-port rewrites and reads that coincide with writes. It compares every read port on every cycle against a behavioural model, so a bad bank copy or a bad owner bit is reported on the first read that reaches it.

// File: rtl/regfile_2w3r.sv
module regfile_2w3r #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wen0,
  input  logic [AW-1:0]        waddr0,
  input  logic [WIDTH-1:0]     wdata0,
  input  logic                 wen1,
  input  logic [AW-1:0]        waddr1,
  input  logic [WIDTH-1:0]     wdata1,
  input  logic [NRD*AW-1:0]    raddr,
  output logic [NRD*WIDTH-1:0] rdata
);

  logic [DEPTH-1:0] owner1;
  wire clash = wen0 && wen1 && (waddr0 == waddr1);

  always_ff @(posedge clk) begin
    if (!rst_n) owner1 <= '0;
    else begin
      if (wen0) owner1[waddr0] <= 1'b0;
      if (wen1) owner1[waddr1] <= 1'b1;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [AW-1:0]    ra;
    logic [WIDTH-1:0] bank0 [DEPTH];
    logic [WIDTH-1:0] bank1 [DEPTH];
    logic [WIDTH-1:0] q0, q1;
    logic             sel1;

    assign ra = raddr[r*AW +: AW];

    always_ff @(posedge clk) begin
      if (wen0) bank0[waddr0] <= wdata0;
      if (wen1) bank1[waddr1] <= wdata1;
      q0 <= bank0[ra];
      q1 <= bank1[ra];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) sel1 <= 1'b0;
      else        sel1 <= owner1[ra];
    end

    assign rdata[r*WIDTH +: WIDTH] = sel1 ? q1 : q0;
  end

  // R8
  owner_reset_chk: assert property (@(posedge clk) $rose(rst_n) |-> owner1 == '0);

  // R4
  collide_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> owner1[$past(waddr1)]);

  // R9
  port0_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wen0 && !clash) |=> !owner1[$past(waddr0)]);

  // R10
  idle_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wen0 && !wen1) |=> $stable(owner1));

endmodule

// File: tb/tb_regfile_2w3r.sv
module tb_regfile_2w3r;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wen0 = 1'b0, wen1 = 1'b0;
  logic [4:0] waddr0 = '0, waddr1 = '0;
  logic [31:0] wdata0 = '0, wdata1 = '0;
  logic [14:0] raddr = '0;
  logic [95:0] rdata;

  always #5 clk = ~clk;

  regfile_2w3r dut (.clk(clk), .rst_n(rst_n), .wen0(wen0), .waddr0(waddr0), .wdata0(wdata0),
                    .wen1(wen1), .waddr1(waddr1), .wdata1(wdata1), .raddr(raddr), .rdata(rdata));

  logic [31:0] cur [32];
  bit          cur_ok [32];
  logic [31:0] b0 [32];
  bit          b0_ok [32];
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic setrd(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c);
    raddr = {c, b, a};
  endtask

  task automatic tick(input string tag);
    logic [31:0] exp [3];
    bit          ok [3];
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin cur[i] = b0[i]; cur_ok[i] = b0_ok[i]; end
    end
    for (int k = 0; k < 3; k++) begin
      exp[k] = cur[raddr[k*5 +: 5]];
      ok[k]  = cur_ok[raddr[k*5 +: 5]];
    end
    if (wen0) begin
      cur[waddr0] = wdata0; cur_ok[waddr0] = 1; b0[waddr0] = wdata0; b0_ok[waddr0] = 1;
    end
    if (wen1) begin cur[waddr1] = wdata1; cur_ok[waddr1] = 1; end
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      if (ok[k]) begin
        checks++;
        if (rdata[k*32 +: 32] !== exp[k]) begin
          errors++;
          $display("FAIL %s port%0d addr %0d: got %h expected %h", tag, k,
                   raddr[k*5 +: 5], rdata[k*32 +: 32], exp[k]);
        end
      end
    end
    wen0 = 0; wen1 = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin cur_ok[i] = 0; b0_ok[i] = 0; cur[i] = '0; b0[i] = '0; end
    repeat (3) tick("R8");
    rst_n = 1;
    // R1
    wen0 = 1; waddr0 = 3; wdata0 = 32'hA5A5_0003; tick("R1");
    setrd(3, 3, 3); tick("R1");
    // R2
    wen1 = 1; waddr1 = 7; wdata1 = 32'h0707_1111; tick("R2");
    setrd(7, 3, 7); tick("R2");
    // R3
    wen0 = 1; waddr0 = 10; wdata0 = 32'h1010_0000; wen1 = 1; waddr1 = 11; wdata1 = 32'h1111_1111;
    tick("R3");
    setrd(10, 11, 3); tick("R3");
    // R4
    wen0 = 1; waddr0 = 12; wdata0 = 32'h1111; wen1 = 1; waddr1 = 12; wdata1 = 32'h2222;
    tick("R4");
    setrd(12, 12, 12); tick("R4");
    // R9
    wen0 = 1; waddr0 = 12; wdata0 = 32'h3333; tick("R9");
    tick("R9");
    // R7
    wen1 = 1; waddr1 = 12; wdata1 = 32'h4444; tick("R7");
    wen0 = 1; waddr0 = 12; wdata0 = 32'h5555; tick("R7");
    tick("R7");
    // R6
    setrd(3, 7, 10); tick("R6");
    setrd(11, 12, 3); tick("R6");
    setrd(7, 3, 12); tick("R6");
    // R10
    waddr0 = 3; wdata0 = 32'hDEAD_BEEF; waddr1 = 7; wdata1 = 32'hBAD0_BAD0;
    setrd(3, 7, 3); tick("R10");
    tick("R10");
    waddr0 = 0; waddr1 = 0; wdata0 = 0; wdata1 = 0;
    // R8
    wen0 = 1; waddr0 = 20; wdata0 = 32'hAAAA_AAAA; tick("R8");
    wen1 = 1; waddr1 = 20; wdata1 = 32'hBBBB_BBBB; tick("R8");
    setrd(20, 20, 7); tick("R8");
    rst_n = 0; tick("R8");
    rst_n = 1; tick("R8");
    tick("R8");
    // R5
    for (int n = 0; n < 4000; n++) begin
      wen0 = $urandom_range(0, 3) != 0;
      wen1 = $urandom_range(0, 3) != 0;
      waddr0 = 5'($urandom);
      waddr1 = (n % 5 == 0) ? waddr0 : 5'($urandom);
      wdata0 = $urandom; wdata1 = $urandom;
      raddr = 15'($urandom);
      tick("R5");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule